// File: doc/BRIEF.md
# Cache Slice Event Counter Unit

This block counts cache-slice events for performance analysis. It holds eight 48-bit counters. Each counter picks one of thirteen event pulse lines through an 8-bit selector code. A counter advances by one on each cycle when three things hold: its selected line is high, its own enable bit is set and the global run bit is set. When a counter rolls over it sets a sticky overflow flag. Any flag that is not masked drives the interrupt output.

Software reaches the unit over a simple register bus. The bus has a 16-bit byte address, separate read and write strobes and a 64-bit data path. A read returns its data on the cycle after the read strobe. Through this bus software programs selector codes, enables and masks, preloads and samples counters, and clears overflow flags by writing ones.

Top module: `evc_unit`

## Requirements
- R1: Counter n is a 48-bit register at address 0x1E00 + 8*n. A write there loads the counter from wdata_i[47:0], and a read returns its value.
- R2: Bits 63:48 of every read response are zero. Writes to those bits of a counter slot have no effect.
- R3: Selector codes are 8 bits each and sit four to a register. Counters 0..3 use address 0x1D00 and counters 4..7 use 0x1D04, with counter n at bits 8*(n mod 4)+7 : 8*(n mod 4). Codes map to event lines as follows: 0x00..0x04 go to lines 0..4, 0x20..0x23 to lines 5..8, 0x29 to line 9, and 0x40..0x42 to lines 10..12.
- R4: A counter whose code is 0xFF, or any code not listed in R3, never advances.
- R5: Bit 16 of the register at 0x0408 is the global run bit. While it is clear, no counter advances.
- R6: Bit n of the register at 0x1C00 enables counter n. A counter advances only when this bit and the global run bit are both set.
- R7: An increment from 2^48-1 wraps the counter to 0 and sets overflow flag n on the same edge, whatever the mask holds.
- R8: The overflow flags read at 0x0808. Writing a 1 to bit n at 0x080C clears flag n, and 0 bits have no effect. If a wrap and a clear hit the same flag on the same edge, the flag stays set.
- R9: The register at 0x0800 holds one mask bit per counter, where 1 blocks and 0 allows. irq_o is the OR over n of flag n AND NOT mask n. It stays high until every unmasked flag is cleared.
- R10: If a bus write to a counter and an increment of that counter fall on the same edge, the written value is kept.
- R11: After reset, counters, enables, flags and the run bit are 0, every mask bit is 1, and every code is 0xFF, so both selector registers read 0xFFFFFFFF.
- R12: rvalid_o is high exactly on the cycle after rd_i, and rdata_o then holds the state from before that edge. Unmapped addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Byte address of the access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 64 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response valid, one cycle after rd_i |
| evt_i | input | 13 | Event pulse lines |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
A wrong selector decode or a wrong enable gate shows on the next counter read as a count that differs from the number of pulse cycles driven. A fault in the overflow flag path is different: a lost flag, a flag that ignores the mask, or a clear that beats a wrap shows on irq_o on the very next cycle, before any read is made. Off-by-one faults at the rollover boundary show as a nonzero value in place of 0. Register aliasing shows as readback differences on the selector and counter slots.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned NUM_LINES = 13;
  localparam int unsigned RUN_BIT   = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 16'h0408;
  localparam logic [ADDR_W-1:0] A_MASK = 16'h0800;
  localparam logic [ADDR_W-1:0] A_STAT = 16'h0808;
  localparam logic [ADDR_W-1:0] A_CLR  = 16'h080C;
  localparam logic [ADDR_W-1:0] A_CEN  = 16'h1C00;
  localparam logic [ADDR_W-1:0] A_SEL0 = 16'h1D00;
  localparam logic [ADDR_W-1:0] A_CNT0 = 16'h1E00;

  localparam logic [CODE_W-1:0] CODE_NONE = 8'hFF;

  typedef struct packed {
    logic       hit;
    logic [3:0] line;
  } line_sel_t;

  function automatic line_sel_t code_to_line(input logic [CODE_W-1:0] code);
    line_sel_t s;
    s = '0;
    if (code <= 8'h04) begin
      s.hit = 1'b1; s.line = code[3:0];
    end else if (code >= 8'h20 && code <= 8'h23) begin
      s.hit = 1'b1; s.line = 4'd5 + {2'b00, code[1:0]};
    end else if (code == 8'h29) begin
      s.hit = 1'b1; s.line = 4'd9;
    end else if (code >= 8'h40 && code <= 8'h42) begin
      s.hit = 1'b1; s.line = 4'd10 + {2'b00, code[1:0]};
    end
    return s;
  endfunction
endpackage

// File: rtl/evc_evsel.sv
module evc_evsel
  import evc_pkg::*;
(
  input  logic [CODE_W-1:0]    code_i,
  input  logic [NUM_LINES-1:0] line_i,
  output logic                 hit_o
);
  line_sel_t sel;

  always_comb begin
    sel   = code_to_line(code_i);
    hit_o = sel.hit && line_i[sel.line];
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // a load on the same edge suppresses the increment and its wrap
  assign wrap_o = inc_i && !load_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evc_unit.sv
module evc_unit
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned DATA_W  = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 rd_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o,
  input  logic [NUM_LINES-1:0] evt_i,
  output logic                 irq_o
);
  localparam int unsigned PER_REG  = 4;
  localparam int unsigned NUM_SEL  = (NUM_CNT + PER_REG - 1) / PER_REG;
  localparam int unsigned CNT_STEP = 8;
  localparam int unsigned SEL_STEP = 4;

  logic                   run_q;
  logic [NUM_CNT-1:0]     cen_q, mask_q, stat_q, wrap_vec, clr_vec;
  logic [CODE_W-1:0]      codes_q [NUM_CNT];
  logic [CNT_W-1:0]       cnt_w   [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]      rdata_d, rdata_q;
  logic                   rvalid_q;
  logic                   unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];

  wire wr_ctrl = wr_i && (addr_i == A_CTRL);
  wire wr_mask = wr_i && (addr_i == A_MASK);
  wire wr_clr  = wr_i && (addr_i == A_CLR);
  wire wr_cen  = wr_i && (addr_i == A_CEN);

  assign clr_vec = wr_clr ? wdata_i[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cen_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (wr_ctrl) run_q  <= wdata_i[RUN_BIT];
      if (wr_cen)  cen_q  <= wdata_i[NUM_CNT-1:0];
      if (wr_mask) mask_q <= wdata_i[NUM_CNT-1:0];
      // a wrap on the same edge outranks the clear
      stat_q <= (stat_q & ~clr_vec) | wrap_vec;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    localparam int unsigned REG  = n / PER_REG;
    localparam int unsigned SLOT = n % PER_REG;
    logic hit, load;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) codes_q[n] <= CODE_NONE;
      else if (wr_i && addr_i == A_SEL0 + ADDR_W'(SEL_STEP*REG))
        codes_q[n] <= wdata_i[CODE_W*SLOT +: CODE_W];
    end

    evc_evsel u_sel (
      .code_i (codes_q[n]),
      .line_i (evt_i),
      .hit_o  (hit)
    );

    assign load = wr_i && (addr_i == A_CNT0 + ADDR_W'(CNT_STEP*n));

    evc_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (wdata_i[CNT_W-1:0]),
      .inc_i      (run_q && cen_q[n] && hit),
      .cnt_o      (cnt_w[n]),
      .wrap_o     (wrap_vec[n])
    );

    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_w[n];
  end

  always_comb begin
    rdata_d = '0;
    if (addr_i == A_CTRL) rdata_d[RUN_BIT]      = run_q;
    if (addr_i == A_MASK) rdata_d[NUM_CNT-1:0]  = mask_q;
    if (addr_i == A_STAT) rdata_d[NUM_CNT-1:0]  = stat_q;
    if (addr_i == A_CEN)  rdata_d[NUM_CNT-1:0]  = cen_q;
    for (int r = 0; r < NUM_SEL; r++) begin
      if (addr_i == A_SEL0 + ADDR_W'(SEL_STEP*r)) begin
        for (int k = 0; k < PER_REG; k++) begin
          if (r*PER_REG + k < NUM_CNT)
            rdata_d[CODE_W*k +: CODE_W] = codes_q[r*PER_REG + k];
        end
      end
    end
    for (int n = 0; n < NUM_CNT; n++) begin
      if (addr_i == A_CNT0 + ADDR_W'(CNT_STEP*n)) rdata_d[CNT_W-1:0] = cnt_w[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign irq_o    = |(stat_q & ~mask_q);
endmodule

// File: rtl/evc_unit_chk.sv
module evc_unit_chk
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned DATA_W  = 64
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        addr_i,
  input logic                     wr_i,
  input logic                     rd_i,
  input logic [DATA_W-1:0]        rdata_o,
  input logic                     rvalid_o,
  input logic                     irq_o,
  input logic                     run_q,
  input logic [NUM_CNT-1:0]       mask_q,
  input logic [NUM_CNT-1:0]       stat_q,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  assert_rsp_follows_rd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  assert_no_rsp_without_rd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[DATA_W-1:CNT_W] == '0));
  assert_hold_when_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_i) |=> $stable(cnt_flat));
  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_CLR) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  assert_irq_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|stat_q));
endmodule

bind evc_unit evc_unit_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .irq_o    (irq_o),
  .run_q    (run_q),
  .mask_q   (mask_q),
  .stat_q   (stat_q),
  .cnt_flat (cnt_flat)
);

// File: tb/evc_unit_bench.sv
module evc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] B_CTRL = 16'h0408, B_MASK = 16'h0800, B_STAT = 16'h0808,
                          B_CLR = 16'h080C, B_CEN = 16'h1C00, B_SEL0 = 16'h1D00,
                          B_SEL1 = 16'h1D04, B_CNT0 = 16'h1E00;
  localparam logic [63:0] MAX48 = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [63:0] wdata = '0;
  logic [12:0] evt = '0;
  logic [63:0] rdata;
  logic        rvalid, irq;

  int checks = 0;
  int failures = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evc_unit u_evc_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .rvalid_o(rvalid), .evt_i(evt), .irq_o(irq)
  );

  function automatic logic [15:0] cnt_addr(input int n);
    return B_CNT0 + 16'(8*n);
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [63:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input logic [12:0] m, input int n);
    @(negedge clk); evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // monitor: pops one expected item per read response
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected response actual=%h expected=none", rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk_irq(1'b0, "R11");
    bus_rd(B_MASK, 64'hFF, "R11 mask");
    bus_rd(B_SEL0, 64'hFFFF_FFFF, "R11 sel0");
    bus_rd(B_SEL1, 64'hFFFF_FFFF, "R11 sel1");
    bus_rd(B_CTRL, 64'h0, "R11 ctrl");
    bus_rd(B_CEN, 64'h0, "R11 enables");
    bus_rd(B_STAT, 64'h0, "R11 status");
    bus_rd(cnt_addr(7), 64'h0, "R11 counter");

    // R1 / R2 load and upper bits ignored
    bus_wr(cnt_addr(2), 64'hABCD_0000_1234_5678);
    bus_rd(cnt_addr(2), 64'h0000_0000_1234_5678, "R1 R2 counter load");
    bus_wr(cnt_addr(2), 64'h0);

    // R3 selector packing
    bus_wr(B_SEL0, 64'hFFFF_2200);
    bus_wr(B_SEL1, 64'hFFFF_4229);
    bus_rd(B_SEL0, 64'hFFFF_2200, "R3 sel0");
    bus_rd(B_SEL1, 64'hFFFF_4229, "R3 sel1");

    // R5 run bit clear
    bus_wr(B_CEN, 64'h33);
    pulse(13'h1FFF, 5);
    bus_rd(cnt_addr(0), 64'h0, "R5 stopped");

    bus_wr(B_CTRL, 64'h1_0000);
    bus_rd(B_CTRL, 64'h1_0000, "R5 run readback");
    pulse(13'h0001, 3);
    bus_rd(cnt_addr(0), 64'd3, "R3 line0");
    bus_rd(cnt_addr(1), 64'd0, "R3 line7 idle");
    pulse(13'h0080, 4);
    bus_rd(cnt_addr(1), 64'd4, "R3 line7");
    pulse(13'h1200, 2);
    bus_rd(cnt_addr(4), 64'd2, "R3 line9");
    bus_rd(cnt_addr(5), 64'd2, "R3 line12");

    // R4 none and unlisted codes
    bus_wr(B_SEL1, 64'hFF10_4229);
    bus_wr(B_CEN, 64'h7B);
    pulse(13'h1FFF, 2);
    bus_rd(cnt_addr(3), 64'd0, "R4 code FF");
    bus_rd(cnt_addr(6), 64'd0, "R4 code 10");
    bus_rd(cnt_addr(1), 64'd6, "R4 neighbour counts");

    // R6 per-counter enable
    bus_wr(B_CEN, 64'h7A);
    pulse(13'h0001, 3);
    bus_rd(cnt_addr(0), 64'd5, "R6 disabled");

    // R7 wrap, R9 mask, R8 clear
    bus_wr(cnt_addr(1), MAX48 - 1);
    pulse(13'h0080, 2);
    bus_rd(cnt_addr(1), 64'd0, "R7 wrap to zero");
    bus_rd(B_STAT, 64'h02, "R7 flag set while masked");
    chk_irq(1'b0, "R9 masked");
    bus_wr(B_MASK, 64'hFD);
    chk_irq(1'b1, "R9 unmasked");
    bus_wr(B_CLR, 64'h00);
    bus_rd(B_STAT, 64'h02, "R8 zero write");
    chk_irq(1'b1, "R9 stays high");
    bus_wr(B_CLR, 64'h02);
    bus_rd(B_STAT, 64'h00, "R8 clear");
    chk_irq(1'b0, "R9 cleared");

    // R10 write beats increment
    @(negedge clk); evt = 13'h0200; addr = cnt_addr(4); wdata = 64'd100; wr = 1'b1;
    @(negedge clk); wr = 1'b0; evt = '0;
    bus_rd(cnt_addr(4), 64'd100, "R10 write wins");

    // R8 wrap beats clear on the same edge
    bus_wr(B_MASK, 64'hDD);
    bus_wr(cnt_addr(5), MAX48);
    @(negedge clk); evt = 13'h1000; addr = B_CLR; wdata = 64'h20; wr = 1'b1;
    @(negedge clk); wr = 1'b0; evt = '0;
    bus_rd(B_STAT, 64'h20, "R8 set wins");
    bus_rd(cnt_addr(5), 64'd0, "R7 wrap c5");
    chk_irq(1'b1, "R9 c5 unmasked");
    bus_wr(B_CLR, 64'h20);
    chk_irq(1'b0, "R9 c5 cleared");

    // R12 unmapped space
    bus_wr(16'h0100, 64'hFFFF_FFFF);
    bus_rd(16'h0100, 64'h0, "R12 unmapped read");
    bus_rd(B_MASK, 64'hDD, "R12 unmapped write");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule